// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero Turnaround

This block is a synchronous memory for a bus on which reads and writes may follow each other on every clock edge. No idle cycle is needed when the bus changes direction. The block registers every command and its address on the rising edge. A read returns its word two enabled edges later. A write takes its data two enabled edges after its command, so the data slot of a write lines up with the slot in which a read would have returned data. The block keeps the address and byte lanes of each write in a short pipeline while the data is still on its way. A read of an address whose newer bytes are not yet in the array gets those bytes merged in.

One supplied address can start a burst of up to four accesses. The burst order is either linear with wrap in the two low address bits, or interleaved. A clock-enable input freezes the whole pipeline. Three chip selects of mixed polarity qualify every command. A sleep input turns commands into deselects and keeps the output enable low. The data bus is split into an input half, an output half and an output-enable bit, so the chip level can build the bidirectional pad.

Top module: `nbl_sram`

## Requirements
- R1: After reset, q_oe is low, no write is pending and no burst is active. An advance cycle right after reset issues no access, so q_oe stays low.
- R2: A read issued at an enabled edge drives q_oe high and the addressed word on q_out after the second enabled edge that follows it.
- R3: The data of a write is sampled from d_in at the second enabled edge after the write command. Reads and writes may alternate on consecutive enabled edges with no idle cycle.
- R4: A word is LANES lanes of 9 bits, with lane i at bits [9i+8:9i] of d_in and q_out. A write changes lane i only where lanes[i] is 1, and a write with lanes all 0 changes nothing.
- R5: A read issued one or two enabled edges after a write to the same address returns that write's enabled lanes merged over the older contents. When two such writes overlap, the newer one wins per lane.
- R6: At an edge where cke is 0, the block ignores every input, d_in included. q_out, q_oe and all pipeline and burst state hold, and nothing is written.
- R7: A selected cycle with load = 1 issues an access at addr, a read when wr_en is 0 and a write when it is 1. Up to three following selected cycles with load = 0 continue the same kind of access at the next burst addresses. A further advance cycle issues nothing.
- R8: With ilv = 0 on the load cycle, beat k (0 to 3) uses the low two address bits (base + k) mod 4. The upper bits stay at the base.
- R9: With ilv = 1 on the load cycle, beat k uses the low two address bits base XOR k. The order is fixed by the ilv value sampled on the load cycle.
- R10: The block is selected only when cs0 = 1, cs1_n = 0 and cs2 = 1. Any other combination is a deselect: it issues no access, ends any burst, and a later advance cycle issues nothing.
- R11: q_oe is low in the output slot of a write, a deselect or an empty advance. The output is never driven while the write data is on the bus.
- R12: An enabled edge with sleep = 1 is treated as a deselect, even with a valid command present, and forces q_oe low at that edge. After sleep is released, q_oe stays low until a newly issued read reaches its output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; 0 ignores the edge |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| wr_en | input | 1 | 1 = write, 0 = read, on load cycles |
| load | input | 1 | 1 = take a new address, 0 = advance the burst |
| ilv | input | 1 | Burst order on load cycles: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request; acts as deselect and blanks the output |
| addr | input | ADDR_W (6) | Word address |
| lanes | input | LANES (4) | Per-lane write enables, taken with the command |
| d_in | input | WORD_W (36) | Write data, input half of the bus |
| q_out | output | WORD_W (36) | Read data, output half of the bus |
| q_oe | output | 1 | Output enable for the read-data slot |

## Verification
The bench goes after the hazards at the pipeline's seams. These are a read one or two slots behind a partial write to the same word, two overlapping partial writes ahead of one read, and stalls inserted while writes and reads are in flight. A design that got any of these wrong would return stale lanes, let the older write win, or take junk data from a stalled d_in. Bursts are run in both orders from a base whose low bits are not zero, and past the fourth beat. Wrong wrap arithmetic would touch the wrong words, and a missing beat limit would keep issuing accesses. Each chip select is dropped alone, and sleep is asserted with a valid read present. A decoder that ignored one select or the sleep input would drive q_oe when the bus belongs to nobody.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

    localparam int ADDR_W    = 6;
    localparam int LANES     = 4;
    localparam int LANE_W    = 9;
    localparam int BEAT_W    = 2;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int LAST_BEAT = (1 << BEAT_W) - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LANES-1:0]  lane_en_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_kind_e;

    // One access as it travels the command pipeline
    typedef struct packed {
        op_kind_e kind;
        addr_t    addr;
        lane_en_t lanes;
    } access_t;

    // A write whose data has arrived
    typedef struct packed {
        logic     vld;
        addr_t    addr;
        lane_en_t lanes;
        word_t    data;
    } wcommit_t;

    localparam access_t IDLE_ACC = '{kind: OP_NONE, addr: '0, lanes: '0};

    // Overlay the enabled lanes of upd onto base
    function automatic word_t lane_merge(input word_t base, input word_t upd, input lane_en_t en);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    // Address of beat k of a burst started at base
    function automatic addr_t beat_addr(input addr_t base, input beat_t k, input logic ilv);
        addr_t r;
        r = base;
        r[BEAT_W-1:0] = ilv ? (base[BEAT_W-1:0] ^ k) : beat_t'(base[BEAT_W-1:0] + k);
        return r;
    endfunction

endpackage

// File: rtl/nbl_burst_ctl.sv
module nbl_burst_ctl
    import nbl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cke,
    input  logic     sleep,
    input  logic     cs0,
    input  logic     cs1_n,
    input  logic     cs2,
    input  logic     load,
    input  logic     wr_en,
    input  logic     ilv,
    input  addr_t    addr,
    input  lane_en_t lanes,
    output access_t  issue
);

    logic     act_q, act_d;
    addr_t    base_q, base_d;
    beat_t    beat_q, beat_d;
    op_kind_e kind_q, kind_d;
    logic     ilv_q, ilv_d;
    logic     selected;

    // sleep folds into the select decode: a sleeping cycle is a deselect
    assign selected = cs0 && !cs1_n && cs2 && !sleep;

    always_comb begin
        act_d       = act_q;
        base_d      = base_q;
        beat_d      = beat_q;
        kind_d      = kind_q;
        ilv_d       = ilv_q;
        issue.kind  = OP_NONE;
        issue.addr  = addr;
        issue.lanes = lanes;
        if (!selected) begin
            act_d = 1'b0;
        end else if (load) begin
            kind_d     = wr_en ? OP_WR : OP_RD;
            act_d      = 1'b1;
            base_d     = addr;
            beat_d     = '0;
            ilv_d      = ilv;
            issue.kind = kind_d;
        end else if (act_q && beat_q != beat_t'(LAST_BEAT)) begin
            beat_d     = beat_q + 1'b1;
            issue.kind = kind_q;
            issue.addr = beat_addr(base_q, beat_d, ilv_q);
        end else begin
            act_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            beat_q <= '0;
            kind_q <= OP_NONE;
            ilv_q  <= 1'b0;
        end else if (cke) begin
            act_q  <= act_d;
            base_q <= base_d;
            beat_q <= beat_d;
            kind_q <= kind_d;
            ilv_q  <= ilv_d;
        end
    end

endmodule

// File: rtl/nbl_mem_array.sv
module nbl_mem_array
    import nbl_pkg::*;
(
    input  logic     clk,
    input  logic     cke,
    input  addr_t    rd_addr,
    output word_t    rd_data,
    input  wcommit_t wr
);

    // One storage column per lane; the read returns the contents before this edge's write
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (cke) begin
                rd_q <= cells[rd_addr];
                if (wr.vld && wr.lanes[g]) begin
                    cells[wr.addr] <= wr.data[g*LANE_W +: LANE_W];
                end
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/nbl_read_merge.sv
module nbl_read_merge
    import nbl_pkg::*;
(
    input  addr_t    rd_addr,
    input  word_t    raw,
    input  wcommit_t older,
    input  wcommit_t newer,
    output word_t    merged
);

    lane_en_t older_en;
    lane_en_t newer_en;
    word_t    partial;

    assign older_en = (older.vld && older.addr == rd_addr) ? older.lanes : '0;
    assign newer_en = (newer.vld && newer.addr == rd_addr) ? newer.lanes : '0;

    // newer write is applied last so it wins lane by lane
    assign partial = lane_merge(raw, older.data, older_en);
    assign merged  = lane_merge(partial, newer.data, newer_en);

endmodule

// File: rtl/nbl_sram.sv
module nbl_sram
    import nbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs0,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              wr_en,
    input  logic              load,
    input  logic              ilv,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes,
    input  logic [WORD_W-1:0] d_in,
    output logic [WORD_W-1:0] q_out,
    output logic              q_oe
);

    access_t  issue;
    access_t  s1_q;
    access_t  s2_q;
    wcommit_t live_w;
    wcommit_t last_q;
    word_t    raw_rd;
    word_t    merged;
    word_t    mid_q;

    nbl_burst_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .cke   (cke),
        .sleep (sleep),
        .cs0   (cs0),
        .cs1_n (cs1_n),
        .cs2   (cs2),
        .load  (load),
        .wr_en (wr_en),
        .ilv   (ilv),
        .addr  (addr),
        .lanes (lanes),
        .issue (issue)
    );

    // The write in the second stage meets its data on d_in at this edge
    always_comb begin
        live_w.vld   = (s2_q.kind == OP_WR);
        live_w.addr  = s2_q.addr;
        live_w.lanes = s2_q.lanes;
        live_w.data  = d_in;
    end

    nbl_mem_array u_mem (
        .clk     (clk),
        .cke     (cke),
        .rd_addr (issue.addr),
        .rd_data (raw_rd),
        .wr      (live_w)
    );

    // The raw word misses the write committed at the read's own issue edge
    // (held in last_q) and the one committing now (live_w)
    nbl_read_merge u_merge (
        .rd_addr (s1_q.addr),
        .raw     (raw_rd),
        .older   (last_q),
        .newer   (live_w),
        .merged  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q       <= IDLE_ACC;
            s2_q       <= IDLE_ACC;
            last_q.vld <= 1'b0;
            q_oe       <= 1'b0;
        end else if (cke) begin
            s1_q   <= issue;
            s2_q   <= s1_q;
            last_q <= live_w;
            q_oe   <= (s2_q.kind == OP_RD) && !sleep;
        end
    end

    always_ff @(posedge clk) begin
        if (cke) begin
            mid_q <= merged;
            q_out <= mid_q;
        end
    end

endmodule

// File: rtl/nbl_sram_chk.sv
module nbl_sram_chk
    import nbl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              sleep,
    input logic              cs0,
    input logic              cs1_n,
    input logic              cs2,
    input logic              q_oe,
    input logic [WORD_W-1:0] q_out,
    input access_t           issue,
    input access_t           s2_acc
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !q_oe);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(q_out) && $stable(q_oe)));

    // R2
    rd_slot_on_chk: assert property (@(posedge clk) disable iff (rst)
        (cke && s2_acc.kind == OP_RD && !sleep) |=> q_oe);

    // R11
    no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (cke && s2_acc.kind != OP_RD) |=> !q_oe);

    // R10
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs0 && !cs1_n && cs2) |-> issue.kind == OP_NONE);

    // R12
    sleep_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> issue.kind == OP_NONE);

    // R12
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cke && sleep) |=> !q_oe);

endmodule

bind nbl_sram nbl_sram_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cke    (cke),
    .sleep  (sleep),
    .cs0    (cs0),
    .cs1_n  (cs1_n),
    .cs2    (cs2),
    .q_oe   (q_oe),
    .q_out  (q_out),
    .issue  (issue),
    .s2_acc (s2_q)
);

// File: tb/nbl_sram_tb.sv
module nbl_sram_tb;
    import nbl_pkg::*;

    logic clk = 1'b0;
    logic rst, cke, cs0, cs1_n, cs2, wr_en, load, ilv, sleep;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
    logic [WORD_W-1:0] d_in;
    logic [WORD_W-1:0] q_out;
    logic              q_oe;

    always #10 clk = ~clk;

    nbl_sram u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs0(cs0), .cs1_n(cs1_n), .cs2(cs2),
        .wr_en(wr_en), .load(load), .ilv(ilv), .sleep(sleep), .addr(addr),
        .lanes(lanes), .d_in(d_in), .q_out(q_out), .q_oe(q_oe)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state: kinds 0 none, 1 read, 2 write
    logic [WORD_W-1:0] ref_mem [DEPTH];
    logic              m_act, m_wr, m_ilv;
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_beat;
    int                h1_k, h2_k;
    logic [ADDR_W-1:0] h1_a, h2_a;
    logic [LANES-1:0]  h1_l, h2_l;
    logic              exp_oe;
    logic [WORD_W-1:0] exp_q;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit en, input bit c0, input bit c1n, input bit c2, input bit we,
                       input bit ld, input bit il, input bit slp,
                       input logic [ADDR_W-1:0] a, input logic [LANES-1:0] l, input string tag);
        logic [WORD_W-1:0] prev_q, din;
        logic              prev_oe, sel;
        int                k;
        logic [ADDR_W-1:0] ia;
        prev_q  = q_out;
        prev_oe = q_oe;
        din     = WORD_W'({$urandom, $urandom});
        cke = en; cs0 = c0; cs1_n = c1n; cs2 = c2; wr_en = we; load = ld;
        ilv = il; sleep = slp; addr = a; lanes = l; d_in = din;
        @(posedge clk);
        if (en) begin
            sel = c0 && !c1n && c2 && !slp;
            k   = 0;
            ia  = a;
            if (!sel) begin
                m_act = 1'b0;
            end else if (ld) begin
                k = we ? 2 : 1;
                m_act = 1'b1; m_base = a; m_beat = 2'd0; m_wr = we; m_ilv = il;
            end else if (m_act && m_beat != 2'd3) begin
                m_beat = m_beat + 2'd1;
                k  = m_wr ? 2 : 1;
                ia = {m_base[ADDR_W-1:2], m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
            end else begin
                m_act = 1'b0;
            end
            if (h2_k == 2) begin
                for (int i = 0; i < LANES; i++) begin
                    if (h2_l[i]) ref_mem[h2_a][i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
                end
            end
            exp_oe = (h2_k == 1) && !slp;
            if (h2_k == 1) exp_q = ref_mem[h2_a];
            h2_k = h1_k; h2_a = h1_a; h2_l = h1_l;
            h1_k = k;    h1_a = ia;   h1_l = l;
        end
        @(negedge clk);
        if (en) begin
            chk(q_oe === exp_oe, tag, "q_oe", q_oe, exp_oe);
            if (exp_oe) chk(q_out === exp_q, tag, "q_out", q_out, exp_q);
        end else begin
            // R6: stalled edge leaves the outputs untouched
            chk(q_oe === prev_oe && q_out === prev_q, "R6", "stall hold", q_out, prev_q);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input bit il, input string t);
        cyc(1, 1, 0, 1, 0, 1, il, 0, a, '1, t);
    endtask
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] l, input bit il, input string t);
        cyc(1, 1, 0, 1, 1, 1, il, 0, a, l, t);
    endtask
    task automatic adv(input logic [LANES-1:0] l, input string t);
        cyc(1, 1, 0, 1, 0, 0, 0, 0, '0, l, t);
    endtask
    task automatic nop(input string t);
        cyc(1, 0, 0, 0, 0, 1, 0, 0, '0, '0, t);
    endtask
    task automatic stall(input string t);
        cyc(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'b0, ADDR_W'($urandom), LANES'($urandom), t);
    endtask

    task automatic run_random(input int n);
        int r;
        logic [ADDR_W-1:0] a;
        logic [LANES-1:0]  l;
        for (int i = 0; i < n; i++) begin
            r = int'($urandom_range(99));
            a = ($urandom_range(3) == 0) ? ADDR_W'($urandom) : ADDR_W'(8 + $urandom_range(7));
            l = LANES'($urandom);
            if (r < 33)       rd(a, 1'($urandom), "R2");
            else if (r < 66)  wr(a, l, 1'($urandom), "R3");
            else if (r < 82)  adv(l, "R7");
            else if (r < 90)  nop("R10");
            else              stall("R6");
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cke = 1'b1; cs0 = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; wr_en = 1'b0;
        load = 1'b1; ilv = 1'b0; sleep = 1'b0; addr = '0; lanes = '0; d_in = '0;
        m_act = 1'b0; m_wr = 1'b0; m_ilv = 1'b0; m_base = '0; m_beat = 2'd0;
        h1_k = 0; h2_k = 0; h1_a = '0; h2_a = '0; h1_l = '0; h2_l = '0;
        exp_oe = 1'b0; exp_q = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(q_oe === 1'b0, "R1", "q_oe after reset", q_oe, 0);

        // R1: no burst is live after reset
        adv('1, "R1"); nop("R1"); nop("R1");

        // R3: fill the array
        for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), '1, 0, "R3");
        nop("R3"); nop("R3");

        // R3: alternating directions with no gap
        for (int i = 0; i < 12; i++) begin
            wr(ADDR_W'(i % 4), LANES'($urandom), 0, "R3");
            rd(ADDR_W'((i + 1) % 4), 0, "R3");
        end
        nop("R3"); nop("R3");

        // R2: single read latency
        rd(6'd10, 0, "R2"); nop("R2"); nop("R2");

        // R4: partial and empty lane masks
        wr(6'd12, 4'b0101, 0, "R4"); nop("R4"); nop("R4");
        rd(6'd12, 0, "R4"); nop("R4"); nop("R4");
        wr(6'd12, 4'b0000, 0, "R4"); nop("R4"); nop("R4");
        rd(6'd12, 0, "R4"); nop("R4"); nop("R4");

        // R5: forwarding at distance one and two, newest wins
        wr(6'd20, 4'b1111, 0, "R5"); wr(6'd20, 4'b0011, 0, "R5"); rd(6'd20, 0, "R5");
        nop("R5"); nop("R5");
        wr(6'd21, 4'b1100, 0, "R5"); rd(6'd21, 0, "R5"); nop("R5"); nop("R5");
        wr(6'd22, 4'b1000, 0, "R5"); nop("R5"); rd(6'd22, 0, "R5"); nop("R5"); nop("R5");
        wr(6'd23, 4'b0110, 0, "R5"); wr(6'd23, 4'b0011, 0, "R5"); rd(6'd23, 0, "R5");
        nop("R5"); nop("R5");

        // R6: stalls with traffic in flight
        wr(6'd30, 4'b1111, 0, "R6"); stall("R6"); stall("R6"); stall("R6");
        rd(6'd30, 0, "R6"); stall("R6"); wr(6'd30, 4'b0010, 0, "R6"); stall("R6");
        rd(6'd30, 0, "R6"); stall("R6"); nop("R6"); stall("R6"); nop("R6"); nop("R6");

        // R8: linear burst from base with low bits 2, then one beat too many (R7)
        rd(6'd6, 0, "R8"); adv('1, "R8"); adv('1, "R8"); adv('1, "R8");
        adv('1, "R7"); nop("R7"); nop("R7");

        // R9: interleaved burst from base with low bits 1
        rd(6'd25, 1, "R9"); adv('1, "R9"); adv('1, "R9"); adv('1, "R9");
        nop("R9"); nop("R9");

        // R7: write burst, then read the words back one by one
        wr(6'd41, 4'b1111, 0, "R7"); adv(4'b0001, "R7"); adv(4'b1010, "R7"); adv(4'b1111, "R7");
        for (int i = 40; i < 44; i++) rd(ADDR_W'(i), 0, "R7");
        nop("R7"); nop("R7");

        // R10: each select wrong on its own, then advance after deselect
        rd(6'd50, 0, "R10");
        cyc(1, 0, 0, 1, 0, 1, 0, 0, 6'd51, '1, "R10");
        adv('1, "R10");
        cyc(1, 1, 1, 1, 0, 1, 0, 0, 6'd52, '1, "R10");
        cyc(1, 1, 0, 0, 0, 1, 0, 0, 6'd53, '1, "R10");
        nop("R10"); nop("R10");

        // R11: output slot off for writes between reads
        rd(6'd1, 0, "R11"); wr(6'd2, 4'b0001, 0, "R11"); rd(6'd3, 0, "R11");
        wr(6'd1, 4'b1000, 0, "R11"); nop("R11"); nop("R11");

        // R12: sleep with a valid read present, then exit
        nop("R12");
        cyc(1, 1, 0, 1, 0, 1, 0, 1, 6'd4, '1, "R12");
        cyc(1, 0, 0, 0, 0, 1, 0, 1, 6'd0, '0, "R12");
        cyc(1, 0, 0, 0, 0, 1, 0, 1, 6'd0, '0, "R12");
        nop("R12"); nop("R12");
        rd(6'd4, 0, "R12"); nop("R12"); nop("R12");

        run_random(4000);
        nop("R2"); nop("R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule